// File: doc/BRIEF.md
# Multi-Cycle Custom Instruction Coprocessor

This unit sits beside the execute stage of a 32-bit pipelined processor and runs custom instructions. Each instruction arrives with a code from a reserved opcode group, two source operands read from general-purpose registers, and a destination register index. The unit holds a single instruction in flight. Its result goes either to the general-purpose register file through a one-cycle write-back strobe or to a special result register that the unit keeps. Every code has its own latency, counted in base-processor cycles.

While an operation is in flight, the unit reports which destination it owns. It blocks any base-processor write that targets that register, and it stalls any further issue. For local state it keeps a bank of internal registers. It also has a lookup scratchpad that a transfer instruction fills from data memory one word per cycle. A lookup instruction can then read several scratchpad entries at once. Codes in the group that no instruction uses are kept for later use: they raise an illegal flag and change nothing.

Top module: `cix_unit`

## Requirements
- R1: Code mapping: 0 multiply, 1 add, 2 local-register write, 3 local-register read, 4 table lookup, 5 table fill. The multiply takes LAT_MUL cycles (default 2), the lookup takes LAT_LUT cycles (default 3), and every other code takes LAT_DEF cycles (default 1). An instruction is accepted at the rising edge where `iss_valid` is high and the unit is idle. Its result is registered at the L-th following edge, and its destination busy flag is high for exactly L cycles.
- R2: The multiply (code 0) writes the low 32 bits of `a*b` into the special result register `spr_data`. It holds `spr_busy` high while in flight and raises no `res_valid`. The special register changes at no other time.
- R3: The add (code 1) returns `a+b` to GPR `iss_dst`. The local write (code 2) stores `a` into local register `b[4:0]` and returns no result. The local read (code 3) returns `local[a[4:0]] + b` to GPR `iss_dst`.
- R4: `base_wblock` is high when `base_we` is high and `base_widx` equals the GPR destination of an in-flight operation. It is low in every other case, including after the result has been written.
- R5: When `iss_valid` is high while the unit is busy, `iss_stall` is high in that cycle and the instruction is not accepted: it produces no result and changes no state.
- R6: Codes 6 and 7 raise `illegal` for the one cycle after the issue edge. They start no operation, produce no result, and leave the local registers and `spr_data` unchanged.
- R7: The table fill (code 5) with base address `a[15:0]` holds `mem_rd` high for 64 consecutive cycles, with `mem_addr` running from base to base+63. Read data is taken one cycle after each request. `fill_done` pulses once, one cycle after the last word is stored, and the unit stalls issue until the fill ends.
- R8: The table lookup (code 4) returns `b ^ T[a[5:0]] ^ T[a[11:6]] ^ T[a[17:12]] ^ T[a[23:18]]` to GPR `iss_dst`, using one 6-bit index per read port (RD_PORTS ports, default 4). T is the scratchpad contents written by the last fill.
- R9: Synchronous reset clears the busy state, `res_valid`, `illegal`, `fill_done`, `spr_data` and all local registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base-processor clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Custom instruction offered this cycle |
| iss_code | input | 3 | Code within the reserved opcode group |
| iss_src_a | input | 32 | First GPR operand |
| iss_src_b | input | 32 | Second GPR operand |
| iss_dst | input | 5 | Destination GPR index |
| iss_stall | output | 1 | Offered instruction held off because the unit is busy |
| res_valid | output | 1 | One-cycle GPR write-back strobe |
| res_dst | output | 5 | GPR index written back |
| res_data | output | 32 | Write-back value |
| spr_data | output | 32 | Special result register |
| dst_busy | output | 1 | A GPR destination is owned by an in-flight operation |
| dst_busy_idx | output | 5 | Index of that GPR |
| spr_busy | output | 1 | Special result register owned by an in-flight operation |
| base_we | input | 1 | Base processor wants to write a GPR |
| base_widx | input | 5 | GPR index of that write |
| base_wblock | output | 1 | That base write must wait |
| illegal | output | 1 | Unused group code seen |
| mem_rd | output | 1 | Data-memory read request during a fill |
| mem_addr | output | 16 | Word address of that request |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| fill_done | output | 1 | Fill finished pulse |

## Verification
The bench measures each latency class by counting busy cycles and finding the cycle in which the result strobe appears. An off-by-one counter shows up as a busy window that is one cycle too long or too short. It offers a second instruction in the middle of a lookup: a unit that accepted it would emit an extra write-back or overwrite the destination. Base-write blocking is probed both on the owned register and on a neighbouring one, and again after completion, so a block that is stuck high or that ignores the index is caught. The fill is checked for 64 strictly consecutive addresses, a single done pulse, and lookup results at entries 0 and 63. Those last checks expose a write index that is misaligned by one against the memory latency. Illegal codes are checked to leave a local register intact, which catches decode that falls through to the write.

// File: rtl/cix_pkg.sv
package cix_pkg;

  typedef enum logic [2:0] {
    K_MUL,
    K_ADD,
    K_LWR,
    K_LRD,
    K_LUT,
    K_FILL,
    K_NONE
  } kind_e;

  typedef struct packed {
    logic  legal;
    kind_e kind;
    logic  to_gpr;
    logic  to_spr;
  } dec_s;

  localparam int OP_MUL  = 0;
  localparam int OP_ADD  = 1;
  localparam int OP_LWR  = 2;
  localparam int OP_LRD  = 3;
  localparam int OP_LUT  = 4;
  localparam int OP_FILL = 5;

endpackage

// File: rtl/cix_decode.sv
module cix_decode
  import cix_pkg::*;
#(
  parameter int CODE_W  = 3,
  parameter int LAT_W   = 4,
  parameter int LAT_MUL = 2,
  parameter int LAT_LUT = 3,
  parameter int LAT_DEF = 1
) (
  input  logic [CODE_W-1:0] code,
  output dec_s              dec,
  output logic [LAT_W-1:0]  lat
);

  always_comb begin
    dec = '{legal: 1'b1, kind: K_NONE, to_gpr: 1'b0, to_spr: 1'b0};
    lat = LAT_W'(LAT_DEF);
    if (code == CODE_W'(OP_MUL)) begin
      dec.kind   = K_MUL;
      dec.to_spr = 1'b1;
      lat        = LAT_W'(LAT_MUL);
    end else if (code == CODE_W'(OP_ADD)) begin
      dec.kind   = K_ADD;
      dec.to_gpr = 1'b1;
    end else if (code == CODE_W'(OP_LWR)) begin
      dec.kind   = K_LWR;
    end else if (code == CODE_W'(OP_LRD)) begin
      dec.kind   = K_LRD;
      dec.to_gpr = 1'b1;
    end else if (code == CODE_W'(OP_LUT)) begin
      dec.kind   = K_LUT;
      dec.to_gpr = 1'b1;
      lat        = LAT_W'(LAT_LUT);
    end else if (code == CODE_W'(OP_FILL)) begin
      dec.kind   = K_FILL;
    end else begin
      dec.legal  = 1'b0;
    end
  end

endmodule

// File: rtl/cix_scratch.sv
module cix_scratch #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int PORTS  = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [PORTS*IDX_W-1:0]  rd_idx,
  output logic [PORTS*DATA_W-1:0] rd_q
);

  // One full copy per read port: each copy is a simple dual-port RAM.
  for (genvar p = 0; p < PORTS; p++) begin : g_bank
    logic [DATA_W-1:0] bank [DEPTH];
    logic [DATA_W-1:0] q_r;

    always_ff @(posedge clk) begin
      if (wr_en) bank[wr_idx] <= wr_data;
      q_r <= bank[rd_idx[p*IDX_W +: IDX_W]];
    end

    assign rd_q[p*DATA_W +: DATA_W] = q_r;
  end

endmodule

// File: rtl/cix_fill.sv
module cix_fill #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  req_q;
  logic              pend_q;
  logic [IDX_W-1:0]  widx_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
      req_q  <= '0;
      pend_q <= 1'b0;
      widx_q <= '0;
      done_q <= 1'b0;
    end else begin
      pend_q <= rd_q;
      widx_q <= req_q;
      done_q <= pend_q && (widx_q == LAST);
      if (go) begin
        rd_q   <= 1'b1;
        addr_q <= base;
        req_q  <= '0;
      end else if (rd_q) begin
        addr_q <= addr_q + 1'b1;
        req_q  <= req_q + 1'b1;
        if (req_q == LAST) rd_q <= 1'b0;
      end
    end
  end

  assign mem_rd   = rd_q;
  assign mem_addr = addr_q;
  assign wr_en    = pend_q;
  assign wr_idx   = widx_q;
  assign wr_data  = mem_rdata;
  assign done     = done_q;

  AST_FILL_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_q && $past(rd_q)) |-> (addr_q == $past(addr_q) + 1'b1)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R7

endmodule

// File: rtl/cix_exec.sv
module cix_exec
  import cix_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GPR_W  = 5,
  parameter int LREG_N = 32,
  parameter int LAT_W  = 4,
  parameter int PORTS  = 4,
  parameter int IDX_W  = 6,
  localparam int LI_W  = $clog2(LREG_N)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    iss_valid,
  input  dec_s                    dec,
  input  logic [LAT_W-1:0]        lat,
  input  logic [DATA_W-1:0]       src_a,
  input  logic [DATA_W-1:0]       src_b,
  input  logic [GPR_W-1:0]        dst,
  input  logic                    base_we,
  input  logic [GPR_W-1:0]        base_widx,
  input  logic                    fill_done,
  input  logic [PORTS*DATA_W-1:0] lut_q,
  output logic [PORTS*IDX_W-1:0]  lut_idx,
  output logic                    fill_go,
  output logic                    iss_stall,
  output logic                    res_valid,
  output logic [GPR_W-1:0]        res_dst,
  output logic [DATA_W-1:0]       res_data,
  output logic [DATA_W-1:0]       spr_data,
  output logic                    dst_busy,
  output logic [GPR_W-1:0]        dst_busy_idx,
  output logic                    spr_busy,
  output logic                    base_wblock,
  output logic                    illegal
);

  logic              busy_q;
  logic [LAT_W-1:0]  cnt_q;
  kind_e             kind_q;
  logic              to_gpr_q;
  logic              to_spr_q;
  logic [GPR_W-1:0]  dst_q;
  logic [DATA_W-1:0] opa_q;
  logic [DATA_W-1:0] opb_q;
  logic              res_valid_q;
  logic [GPR_W-1:0]  res_dst_q;
  logic [DATA_W-1:0] res_data_q;
  logic [DATA_W-1:0] spr_q;
  logic              illegal_q;
  logic [DATA_W-1:0] lreg_q [LREG_N];

  logic              accept;
  logic [DATA_W-1:0] lut_x;
  logic [DATA_W-1:0] result;

  assign accept  = iss_valid && !busy_q && dec.legal;
  assign fill_go = accept && (dec.kind == K_FILL);
  assign lut_idx = opa_q[PORTS*IDX_W-1:0];

  always_comb begin
    lut_x = opb_q;
    for (int p = 0; p < PORTS; p++) lut_x = lut_x ^ lut_q[p*DATA_W +: DATA_W];
    case (kind_q)
      K_ADD:   result = opa_q + opb_q;
      K_LRD:   result = lreg_q[opa_q[LI_W-1:0]] + opb_q;
      K_LUT:   result = lut_x;
      default: result = opa_q * opb_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      kind_q      <= K_NONE;
      to_gpr_q    <= 1'b0;
      to_spr_q    <= 1'b0;
      dst_q       <= '0;
      opa_q       <= '0;
      opb_q       <= '0;
      res_valid_q <= 1'b0;
      res_dst_q   <= '0;
      res_data_q  <= '0;
      spr_q       <= '0;
      illegal_q   <= 1'b0;
      for (int i = 0; i < LREG_N; i++) lreg_q[i] <= '0;
    end else begin
      res_valid_q <= 1'b0;
      illegal_q   <= iss_valid && !busy_q && !dec.legal;
      if (accept) begin
        busy_q   <= 1'b1;
        cnt_q    <= lat;
        kind_q   <= dec.kind;
        to_gpr_q <= dec.to_gpr;
        to_spr_q <= dec.to_spr;
        dst_q    <= dst;
        opa_q    <= src_a;
        opb_q    <= src_b;
      end else if (busy_q) begin
        if (kind_q == K_FILL) begin
          if (fill_done) busy_q <= 1'b0;
        end else if (cnt_q <= LAT_W'(1)) begin
          busy_q <= 1'b0;
          if (to_gpr_q) begin
            res_valid_q <= 1'b1;
            res_dst_q   <= dst_q;
            res_data_q  <= result;
          end
          if (to_spr_q) spr_q <= result;
          if (kind_q == K_LWR) lreg_q[opb_q[LI_W-1:0]] <= opa_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign iss_stall    = iss_valid && busy_q;
  assign res_valid    = res_valid_q;
  assign res_dst      = res_dst_q;
  assign res_data     = res_data_q;
  assign spr_data     = spr_q;
  assign dst_busy     = busy_q && to_gpr_q;
  assign dst_busy_idx = dst_q;
  assign spr_busy     = busy_q && to_spr_q;
  assign base_wblock  = base_we && dst_busy && (base_widx == dst_q);
  assign illegal      = illegal_q;

  AST_RES_AFTER_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
    res_valid_q |-> $past(busy_q)); // R1
  AST_SPR_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !$past(busy_q)) |-> $stable(spr_q)); // R2
  AST_BLOCK_NOT_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    base_wblock |-> !res_valid_q); // R4
  AST_ILLEGAL_NO_START: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> !busy_q); // R6

endmodule

// File: rtl/cix_unit.sv
module cix_unit #(
  parameter int DATA_W   = 32,
  parameter int GPR_W    = 5,
  parameter int CODE_W   = 3,
  parameter int LREG_N   = 32,
  parameter int SP_DEPTH = 64,
  parameter int RD_PORTS = 4,
  parameter int ADDR_W   = 16,
  parameter int LAT_W    = 4,
  parameter int LAT_MUL  = 2,
  parameter int LAT_LUT  = 3,
  parameter int LAT_DEF  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [CODE_W-1:0] iss_code,
  input  logic [DATA_W-1:0] iss_src_a,
  input  logic [DATA_W-1:0] iss_src_b,
  input  logic [GPR_W-1:0]  iss_dst,
  output logic              iss_stall,
  output logic              res_valid,
  output logic [GPR_W-1:0]  res_dst,
  output logic [DATA_W-1:0] res_data,
  output logic [DATA_W-1:0] spr_data,
  output logic              dst_busy,
  output logic [GPR_W-1:0]  dst_busy_idx,
  output logic              spr_busy,
  input  logic              base_we,
  input  logic [GPR_W-1:0]  base_widx,
  output logic              base_wblock,
  output logic              illegal,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fill_done
);

  localparam int IDX_W = $clog2(SP_DEPTH);

  cix_pkg::dec_s                dec;
  logic [LAT_W-1:0]             lat;
  logic                         fill_go;
  logic                         sp_we;
  logic [IDX_W-1:0]             sp_widx;
  logic [DATA_W-1:0]            sp_wdata;
  logic [RD_PORTS*IDX_W-1:0]    lut_idx;
  logic [RD_PORTS*DATA_W-1:0]   lut_q;

  cix_decode #(
    .CODE_W(CODE_W), .LAT_W(LAT_W),
    .LAT_MUL(LAT_MUL), .LAT_LUT(LAT_LUT), .LAT_DEF(LAT_DEF)
  ) u_decode (
    .code(iss_code), .dec(dec), .lat(lat)
  );

  cix_exec #(
    .DATA_W(DATA_W), .GPR_W(GPR_W), .LREG_N(LREG_N),
    .LAT_W(LAT_W), .PORTS(RD_PORTS), .IDX_W(IDX_W)
  ) u_exec (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .dec(dec), .lat(lat),
    .src_a(iss_src_a), .src_b(iss_src_b), .dst(iss_dst),
    .base_we(base_we), .base_widx(base_widx), .fill_done(fill_done),
    .lut_q(lut_q), .lut_idx(lut_idx), .fill_go(fill_go),
    .iss_stall(iss_stall), .res_valid(res_valid), .res_dst(res_dst),
    .res_data(res_data), .spr_data(spr_data), .dst_busy(dst_busy),
    .dst_busy_idx(dst_busy_idx), .spr_busy(spr_busy),
    .base_wblock(base_wblock), .illegal(illegal)
  );

  cix_fill #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(SP_DEPTH)
  ) u_fill (
    .clk(clk), .rst(rst), .go(fill_go), .base(iss_src_a[ADDR_W-1:0]),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .wr_en(sp_we), .wr_idx(sp_widx), .wr_data(sp_wdata), .done(fill_done)
  );

  cix_scratch #(
    .DATA_W(DATA_W), .DEPTH(SP_DEPTH), .PORTS(RD_PORTS)
  ) u_scratch (
    .clk(clk), .wr_en(sp_we), .wr_idx(sp_widx), .wr_data(sp_wdata),
    .rd_idx(lut_idx), .rd_q(lut_q)
  );

endmodule

// File: tb/cix_unit_bench.sv
module cix_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic [2:0]  iss_code = '0;
  logic [31:0] iss_src_a = '0;
  logic [31:0] iss_src_b = '0;
  logic [4:0]  iss_dst = '0;
  logic        iss_stall;
  logic        res_valid;
  logic [4:0]  res_dst;
  logic [31:0] res_data;
  logic [31:0] spr_data;
  logic        dst_busy;
  logic [4:0]  dst_busy_idx;
  logic        spr_busy;
  logic        base_we = 1'b0;
  logic [4:0]  base_widx = '0;
  logic        base_wblock;
  logic        illegal;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        fill_done;

  int checks = 0;
  int fails  = 0;
  int rd_cnt = 0;
  int step_err = 0;
  int done_cnt = 0;
  logic [15:0] first_addr = '0;
  logic [15:0] last_addr = '0;

  localparam logic [15:0] FILL_BASE = 16'h0100;

  always #4 clk = ~clk;

  cix_unit u_cix_unit (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_code(iss_code),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
    .iss_stall(iss_stall), .res_valid(res_valid), .res_dst(res_dst),
    .res_data(res_data), .spr_data(spr_data), .dst_busy(dst_busy),
    .dst_busy_idx(dst_busy_idx), .spr_busy(spr_busy), .base_we(base_we),
    .base_widx(base_widx), .base_wblock(base_wblock), .illegal(illegal),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .fill_done(fill_done)
  );

  function automatic logic [31:0] memf(input logic [15:0] addr);
    return (32'h9E3779B9 * {16'h0, addr}) + 32'h1357;
  endfunction

  // Data-memory model with one cycle of read latency.
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= memf(mem_addr);
      if (rd_cnt == 0) first_addr = mem_addr;
      else if (mem_addr != last_addr + 16'd1) step_err++;
      last_addr = mem_addr;
      rd_cnt++;
    end
    if (fill_done) done_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Offer one instruction for one edge; returns at the negedge after acceptance.
  task automatic issue(input logic [2:0] code, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] dst);
    @(negedge clk);
    iss_valid = 1'b1; iss_code = code; iss_src_a = a; iss_src_b = b; iss_dst = dst;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  // Runs an op for 12 cycles, counting busy cycles and the first result cycle.
  task automatic run_op(input logic [2:0] code, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] dst,
                        output int busy_n, output int res_n, output int res_cnt,
                        output logic [31:0] data, output logic [4:0] rdst);
    issue(code, a, b, dst);
    busy_n = 0; res_n = 0; res_cnt = 0; data = '0; rdst = '0;
    for (int n = 1; n <= 12; n++) begin
      if (dst_busy || spr_busy) busy_n++;
      if (res_valid) begin
        res_cnt++;
        if (res_n == 0) begin res_n = n; data = res_data; rdst = res_dst; end
      end
      if (n < 12) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 res_valid after reset", {31'd0, res_valid}, 32'd0);
    chk("R9 busy after reset", {30'd0, dst_busy, spr_busy}, 32'd0);
    chk("R9 illegal after reset", {31'd0, illegal}, 32'd0);
    chk("R9 fill_done after reset", {31'd0, fill_done}, 32'd0);
    chk("R9 spr after reset", spr_data, 32'd0);
  endtask

  task automatic t_local_zero();
    int bn, rn, rc; logic [31:0] d; logic [4:0] rd;
    run_op(3'd3, 32'd5, 32'd100, 5'd4, bn, rn, rc, d, rd);
    chk("R9 local reg cleared (read returns b)", d, 32'd100);
    chk("R3 local read dst", {27'd0, rd}, 32'd4);
  endtask

  task automatic t_add();
    int bn, rn, rc; logic [31:0] d; logic [4:0] rd;
    run_op(3'd1, 32'h1234_5678, 32'h0F0F_0F0F, 5'd7, bn, rn, rc, d, rd);
    chk("R1 add busy cycles", bn, 32'd1);
    chk("R1 add result cycle", rn, 32'd2);
    chk("R3 add value", d, 32'h2143_6587);
    chk("R3 add dst", {27'd0, rd}, 32'd7);
  endtask

  task automatic t_mul();
    int bn, rn, rc; logic [31:0] d; logic [4:0] rd;
    logic [31:0] a = 32'h0001_2345, b = 32'h0000_F00D;
    logic [63:0] p = {32'd0, a} * {32'd0, b};
    run_op(3'd0, a, b, 5'd2, bn, rn, rc, d, rd);
    chk("R1 mul busy cycles", bn, 32'd2);
    chk("R2 mul no gpr result", rc, 32'd0);
    chk("R2 mul spr value", spr_data, p[31:0]);
  endtask

  task automatic t_local_rw();
    int bn, rn, rc; logic [31:0] d; logic [4:0] rd;
    run_op(3'd2, 32'h0000_DEAD, 32'd5, 5'd0, bn, rn, rc, d, rd);
    chk("R3 local write gives no result", rc, 32'd0);
    run_op(3'd3, 32'd5, 32'd1, 5'd6, bn, rn, rc, d, rd);
    chk("R3 local read after write", d, 32'h0000_DEAE);
  endtask

  task automatic t_fill();
    int rc0 = rd_cnt, dc0 = done_cnt, res_seen = 0, waited = 0;
    issue(3'd5, {16'd0, FILL_BASE}, 32'd0, 5'd0);
    iss_valid = 1'b1; iss_code = 3'd1; iss_src_a = 32'd1; iss_src_b = 32'd1; iss_dst = 5'd3;
    #1 chk("R7 stall during fill", {31'd0, iss_stall}, 32'd1);
    @(negedge clk);
    iss_valid = 1'b0;
    while (done_cnt == dc0 && waited < 200) begin
      if (res_valid) res_seen++;
      @(negedge clk);
      waited++;
    end
    repeat (3) @(negedge clk);
    chk("R7 read count", rd_cnt - rc0, 32'd64);
    chk("R7 first address", {16'd0, first_addr}, {16'd0, FILL_BASE});
    chk("R7 last address", {16'd0, last_addr}, {16'd0, FILL_BASE + 16'd63});
    chk("R7 address steps", step_err, 32'd0);
    chk("R7 one done pulse", done_cnt - dc0, 32'd1);
    chk("R5 stalled add not executed", res_seen, 32'd0);
    iss_valid = 1'b1; iss_code = 3'd1;
    #1 chk("R7 no stall after fill", {31'd0, iss_stall}, 32'd0);
    iss_valid = 1'b0;
  endtask

  task automatic t_lut_block_stall();
    logic [31:0] a = {8'd0, 6'd42, 6'd17, 6'd63, 6'd0};
    logic [31:0] b = 32'h0000_0055;
    logic [31:0] exp = b ^ memf(FILL_BASE) ^ memf(FILL_BASE + 16'd63)
                       ^ memf(FILL_BASE + 16'd17) ^ memf(FILL_BASE + 16'd42);
    int bn = 0, rn = 0, rc = 0; logic [31:0] d = '0; logic [4:0] rd = '0;
    issue(3'd4, a, b, 5'd9);
    base_we = 1'b1; base_widx = 5'd9;
    #1 chk("R4 block on owned dst", {31'd0, base_wblock}, 32'd1);
    chk("R4 busy index", {27'd0, dst_busy_idx}, 32'd9);
    base_widx = 5'd10;
    #1 chk("R4 no block other reg", {31'd0, base_wblock}, 32'd0);
    base_we = 1'b0;
    iss_valid = 1'b1; iss_code = 3'd1; iss_src_a = 32'd1; iss_src_b = 32'd2; iss_dst = 5'd3;
    #1 chk("R5 stall while busy", {31'd0, iss_stall}, 32'd1);
    for (int n = 1; n <= 12; n++) begin
      if (dst_busy) bn++;
      if (res_valid) begin
        rc++;
        if (rn == 0) begin rn = n; d = res_data; rd = res_dst; end
      end
      @(negedge clk);
      iss_valid = 1'b0;
    end
    chk("R1 lookup busy cycles", bn, 32'd3);
    chk("R1 lookup result cycle", rn, 32'd4);
    chk("R8 lookup value", d, exp);
    chk("R5 only one result", rc, 32'd1);
    chk("R5 result dst is lookup dst", {27'd0, rd}, 32'd9);
    base_we = 1'b1; base_widx = 5'd9;
    #1 chk("R4 no block after completion", {31'd0, base_wblock}, 32'd0);
    base_we = 1'b0;
  endtask

  task automatic t_illegal();
    int bn, rn, rc; logic [31:0] d; logic [4:0] rd;
    logic [31:0] spr0 = spr_data;
    issue(3'd6, 32'd0, 32'd5, 5'd8);
    chk("R6 illegal pulse", {31'd0, illegal}, 32'd1);
    chk("R6 no busy", {30'd0, dst_busy, spr_busy}, 32'd0);
    @(negedge clk);
    chk("R6 illegal one cycle", {31'd0, illegal}, 32'd0);
    issue(3'd7, 32'd0, 32'd5, 5'd8);
    chk("R6 code 7 illegal", {31'd0, illegal}, 32'd1);
    chk("R6 no result", {31'd0, res_valid}, 32'd0);
    run_op(3'd3, 32'd5, 32'd0, 5'd6, bn, rn, rc, d, rd);
    chk("R6 local reg unchanged", d, 32'h0000_DEAD);
    chk("R6 spr unchanged", spr_data, spr0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_local_zero();
    t_add();
    t_mul();
    t_local_rw();
    t_fill();
    t_lut_block_stall();
    t_illegal();
    repeat (4) @(negedge clk);
    summary();
  end

endmodule